// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Generator

This block produces the two early-warning fill flags of a dual-clock FIFO whose depth is set by a parameter. It does not contain the storage array or the exact empty and full flags. The almost-empty flag `ae_n` is active low and belongs to the read clock domain. The almost-full flag `af_n` is active low and belongs to the write clock domain. Each side receives its own pointer in binary form. The pointer of the opposite side arrives in Gray code, and the block passes it through a synchronizer chain that it owns.

Two offset registers set how close to empty or full a flag trips. The low-water offset is called X and the high-water offset is called Y. Both registers sit in the write clock domain and take a preset value on reset. They can be rewritten one at a time through a parallel load port, or together through a single-bit serial shift port. An offset that is equal to or larger than the depth acts as depth minus one. The read side reads X directly and assumes it is changed only while the FIFO is quiet.

Top module: `afae_flags`

## Requirements
- R1: The fill level seen by the read side is the synchronized write pointer minus the local read pointer, modulo 2^(ADDR_W+1). A word already handed to the output register counts as read. `ae_n` is 0 when this level is at most the effective X and 1 when it is at least effective X + 1.
- R2: The fill level seen by the write side is the local write pointer minus the synchronized read pointer. `af_n` is 0 when this level is at least DEPTH minus the effective Y and 1 when it is at most DEPTH minus (effective Y + 1).
- R3: The write pointer Gray code may change just after a falling read clock edge and raise the level to effective X + 1. In that case `ae_n` is still 0 after the next rising `rclk` edge and is 1 after the second. A change of the local `rd_ptr` affects `ae_n` without any clock edge.
- R4: The read pointer Gray code may change just after a falling write clock edge and lower the level to DEPTH minus (effective Y + 1). In that case `af_n` is still 0 after the next rising `wclk` edge and is 1 after the second. A change of the local `wr_ptr` affects `af_n` without any clock edge.
- R5: While `wrst_n` is low, X and Y load PRESET, which defaults to 2. With both pointers at 0 after reset, `ae_n` is 0 and `af_n` is 1.
- R6: On a `wclk` edge with `ld_en` = 1, `ld_data` is written to X when `ld_sel` = 0 and to Y when `ld_sel` = 1.
- R7: On a `wclk` edge with `ser_en` = 1 and `ld_en` = 0, the 2*OFS_W-bit chain {X, Y} shifts left by one and `ser_in` enters at bit 0 of Y. Offsets are therefore loaded X first, most significant bit first, over 2*OFS_W clocks. When `ld_en` and `ser_en` are both 1, the parallel load wins and the serial bit is dropped, so the register that is not addressed keeps its value.
- R8: An offset value of DEPTH or more behaves exactly as DEPTH - 1.
- R9: While `ld_en` and `ser_en` are both 0, X and Y keep their values whatever `ld_data` and `ser_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Synchronous active-low reset, write side |
| wr_ptr | input | ADDR_W+1 | Local binary write pointer |
| rd_ptr_gray | input | ADDR_W+1 | Read pointer in Gray code, from the read domain |
| ld_en | input | 1 | Parallel offset load strobe |
| ld_sel | input | 1 | Parallel target: 0 = X, 1 = Y |
| ld_data | input | OFS_W | Parallel offset value |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial offset bit |
| af_n | output | 1 | Almost-full flag, active low |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Synchronous active-low reset, read side |
| rd_ptr | input | ADDR_W+1 | Local binary read pointer |
| wr_ptr_gray | input | ADDR_W+1 | Write pointer in Gray code, from the write domain |
| ae_n | output | 1 | Almost-empty flag, active low |

## Verification
A parallel load strobe and a serial shift can both be active on the same write clock edge, and only one of them may act. The bench provokes this by raising `ld_en` and `ser_en` in the same cycle with `ser_in` at 1. It then sweeps the fill level across both thresholds. The new X must show at the low-water boundary, while the high-water boundary must still follow the old Y, which a shift would have altered. On the read side, a remote pointer change and a local pointer change can arrive close together. The bench moves the Gray write pointer across the boundary and counts `rclk` edges until `ae_n` rises, then moves `rd_ptr` back and expects `ae_n` to fall with no edge at all.

// File: rtl/afae_pkg.sv
// Package: shared types and helpers for the almost-empty/almost-full flag block.
// Assumes offsets and levels fit in 32 bits.
package afae_pkg;

    // Target of a parallel offset load
    typedef enum logic {
        OFS_LOW  = 1'b0,
        OFS_HIGH = 1'b1
    } ofs_sel_e;

    // Clamp an offset so it never reaches the FIFO depth
    function automatic logic [31:0] clamp_ofs(input logic [31:0] raw, input logic [31:0] depth);
        return (raw >= depth) ? depth - 32'd1 : raw;
    endfunction

endpackage

// File: rtl/afae_ptr_sync.sv
// Module: afae_ptr_sync
// Carries a Gray-coded pointer from another clock domain through a chain of
// SYNC_STAGES flops and converts the last stage to binary.
// Assumes the source changes by at most one Gray step per source clock.
module afae_ptr_sync #(
    parameter int PTR_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] gray_in,
    output logic [PTR_W-1:0] bin_out
);

    logic [PTR_W-1:0] stg [SYNC_STAGES];

    // Shift the remote Gray pointer through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= gray_in;
            for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    // Gray to binary: each bit is the parity of the Gray bits at and above it
    always_comb begin
        for (int i = 0; i < PTR_W; i++) bin_out[i] = ^(stg[SYNC_STAGES-1] >> i);
    end

endmodule

// File: rtl/afae_ofs_regs.sv
// Module: afae_ofs_regs
// Holds the low-water (X) and high-water (Y) offsets. They preset on reset,
// load in parallel, or shift in serially as one chain {X, Y}, X first, MSB first.
// A parallel load has priority over a serial shift in the same cycle.
module afae_ofs_regs
    import afae_pkg::*;
#(
    parameter int OFS_W  = 5,
    parameter int PRESET = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             ld_sel,
    input  logic [OFS_W-1:0] ld_data,
    input  logic             ser_en,
    input  logic             ser_in,
    output logic [OFS_W-1:0] x_q,
    output logic [OFS_W-1:0] y_q
);

    localparam logic [OFS_W-1:0] PRESET_V = OFS_W'(PRESET);

    // Preset, parallel write or serial shift of the offset pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= PRESET_V;
            y_q <= PRESET_V;
        end else if (ld_en) begin
            if (ofs_sel_e'(ld_sel) == OFS_HIGH) y_q <= ld_data;
            else                                x_q <= ld_data;
        end else if (ser_en) begin
            {x_q, y_q} <= {x_q[OFS_W-2:0], y_q, ser_in};
        end
    end

endmodule

// File: rtl/afae_level_cmp.sv
// Module: afae_level_cmp
// Computes the fill level from a leading and a trailing binary pointer and
// compares it with a clamped offset. FULL_SIDE selects the high-water test.
// Assumes the pointers have one wrap bit above the address bits.
module afae_level_cmp
    import afae_pkg::*;
#(
    parameter int PTR_W     = 5,
    parameter int OFS_W     = 5,
    parameter int DEPTH     = 16,
    parameter bit FULL_SIDE = 1'b0
) (
    input  logic [PTR_W-1:0] lead_ptr,
    input  logic [PTR_W-1:0] trail_ptr,
    input  logic [OFS_W-1:0] ofs,
    output logic             flag_n
);

    localparam logic [31:0] DEPTH_V = 32'(DEPTH);

    logic [PTR_W-1:0] level;
    logic [31:0]      lvl32;
    logic [31:0]      eff32;

    // Modular distance between the pointers and the saturated offset
    always_comb begin
        level = lead_ptr - trail_ptr;
        lvl32 = 32'(level);
        eff32 = clamp_ofs(32'(ofs), DEPTH_V);
    end

    generate
        if (FULL_SIDE) begin : g_high
            // Deasserted (1) while the level stays below depth minus offset
            always_comb flag_n = (lvl32 < (DEPTH_V - eff32));
        end else begin : g_low
            // Deasserted (1) once the level exceeds the offset
            always_comb flag_n = (lvl32 > eff32);
        end
    endgenerate

endmodule

// File: rtl/afae_flags.sv
// Module: afae_flags (top)
// Almost-empty flag in the read domain and almost-full flag in the write
// domain for a FIFO of 2**ADDR_W words. Remote pointers arrive in Gray code
// and are synchronized here. Offsets are programmed on the write side.
// Assumes X is changed only while the FIFO is idle, because the read side
// uses it without resynchronization.
module afae_flags #(
    parameter int ADDR_W      = 4,
    parameter int OFS_W       = ADDR_W + 1,
    parameter int PRESET      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic [ADDR_W:0]   wr_ptr,
    input  logic [ADDR_W:0]   rd_ptr_gray,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [OFS_W-1:0]  ld_data,
    input  logic              ser_en,
    input  logic              ser_in,
    output logic              af_n,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic [ADDR_W:0]   rd_ptr,
    input  logic [ADDR_W:0]   wr_ptr_gray,
    output logic              ae_n
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [OFS_W-1:0] x_q;
    logic [OFS_W-1:0] y_q;
    logic [PTR_W-1:0] wbin_rs;
    logic [PTR_W-1:0] rbin_ws;

    afae_ofs_regs #(.OFS_W(OFS_W), .PRESET(PRESET)) u_ofs (
        .clk(wclk), .rst_n(wrst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_data(ld_data), .ser_en(ser_en), .ser_in(ser_in),
        .x_q(x_q), .y_q(y_q)
    );

    afae_ptr_sync #(.PTR_W(PTR_W), .SYNC_STAGES(SYNC_STAGES)) u_wsync (
        .clk(rclk), .rst_n(rrst_n), .gray_in(wr_ptr_gray), .bin_out(wbin_rs)
    );

    afae_ptr_sync #(.PTR_W(PTR_W), .SYNC_STAGES(SYNC_STAGES)) u_rsync (
        .clk(wclk), .rst_n(wrst_n), .gray_in(rd_ptr_gray), .bin_out(rbin_ws)
    );

    afae_level_cmp #(.PTR_W(PTR_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .FULL_SIDE(1'b0)) u_low (
        .lead_ptr(wbin_rs), .trail_ptr(rd_ptr), .ofs(x_q), .flag_n(ae_n)
    );

    afae_level_cmp #(.PTR_W(PTR_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .FULL_SIDE(1'b1)) u_high (
        .lead_ptr(wr_ptr), .trail_ptr(rbin_ws), .ofs(y_q), .flag_n(af_n)
    );

endmodule

// File: rtl/afae_flags_chk.sv
// Module: afae_flags_chk
// Property checker for afae_flags, attached with bind below.
module afae_flags_chk #(
    parameter int OFS_W  = 5,
    parameter int PTR_W  = 5,
    parameter int PRESET = 2
) (
    input logic             wclk,
    input logic             wrst_n,
    input logic             rclk,
    input logic             rrst_n,
    input logic             ld_en,
    input logic             ld_sel,
    input logic [OFS_W-1:0] ld_data,
    input logic             ser_en,
    input logic             ser_in,
    input logic [OFS_W-1:0] x_q,
    input logic [OFS_W-1:0] y_q,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] wbin_rs,
    input logic [PTR_W-1:0] rbin_ws,
    input logic             af_n,
    input logic             ae_n
);

    logic rst_seen = 1'b0;

    // Remember that the previous write edge was in reset
    always_ff @(posedge wclk) rst_seen <= !wrst_n;

    // R5: first cycle out of reset shows the preset offsets
    a_r5_preset: assert property (@(posedge wclk) disable iff (!wrst_n)
        rst_seen |-> (x_q == OFS_W'(PRESET) && y_q == OFS_W'(PRESET)));

    // R6: parallel load to X
    a_r6_load_x: assert property (@(posedge wclk) disable iff (!wrst_n)
        (ld_en && !ld_sel) |=> (x_q == $past(ld_data)));

    // R6: parallel load to Y
    a_r6_load_y: assert property (@(posedge wclk) disable iff (!wrst_n)
        (ld_en && ld_sel) |=> (y_q == $past(ld_data)));

    // R7: serial shift moves the chain by one bit
    a_r7_serial_shift: assert property (@(posedge wclk) disable iff (!wrst_n)
        (ser_en && !ld_en) |=> (y_q[0] == $past(ser_in) && x_q[0] == $past(y_q[OFS_W-1])));

    // R7: parallel load to X beats a same-cycle shift, Y untouched
    a_r7_priority: assert property (@(posedge wclk) disable iff (!wrst_n)
        (ld_en && ser_en && !ld_sel) |=> $stable(y_q));

    // R9: no enable, no change
    a_r9_hold: assert property (@(posedge wclk) disable iff (!wrst_n)
        (!ld_en && !ser_en) |=> ($stable(x_q) && $stable(y_q)));

    // R3: ae_n rises only after a synced write, a pointer move or an X change
    a_r3_ae_rise_cause: assert property (@(posedge rclk) disable iff (!rrst_n)
        $rose(ae_n) |-> (wbin_rs != $past(wbin_rs) || rd_ptr != $past(rd_ptr) || x_q != $past(x_q)));

    // R4: af_n rises only after a synced read, a pointer move or a Y change
    a_r4_af_rise_cause: assert property (@(posedge wclk) disable iff (!wrst_n)
        $rose(af_n) |-> (rbin_ws != $past(rbin_ws) || wr_ptr != $past(wr_ptr) || y_q != $past(y_q)));

endmodule

bind afae_flags afae_flags_chk #(.OFS_W(OFS_W), .PTR_W(PTR_W), .PRESET(PRESET)) u_chk (
    .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .ser_en(ser_en), .ser_in(ser_in), .x_q(x_q), .y_q(y_q),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wbin_rs(wbin_rs), .rbin_ws(rbin_ws),
    .af_n(af_n), .ae_n(ae_n)
);

// File: tb/sim_afae_flags.sv
`timescale 1ns/1ps
// Bench for afae_flags: directed corners plus seeded random programming and levels.
module sim_afae_flags;
    localparam int ADDR_W = 4;
    localparam int OFS_W  = 5;
    localparam int PTR_W  = 5;
    localparam int DEPTH  = 16;
    localparam int PRESET = 2;

    logic wclk = 1'b0, rclk = 1'b0, wrst_n = 1'b0, rrst_n = 1'b0;
    logic [PTR_W-1:0] wr_ptr = '0, rd_ptr = '0, wr_ptr_gray = '0, rd_ptr_gray = '0;
    logic ld_en = 1'b0, ld_sel = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
    logic [OFS_W-1:0] ld_data = '0;
    logic af_n, ae_n;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [OFS_W-1:0] mx = OFS_W'(PRESET), my = OFS_W'(PRESET);
    logic [PTR_W-1:0] cur_w = '0, cur_r = '0;

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    afae_flags #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PRESET(PRESET)) u0 (
        .wclk(wclk), .wrst_n(wrst_n), .wr_ptr(wr_ptr), .rd_ptr_gray(rd_ptr_gray),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data), .ser_en(ser_en),
        .ser_in(ser_in), .af_n(af_n), .rclk(rclk), .rrst_n(rrst_n),
        .rd_ptr(rd_ptr), .wr_ptr_gray(wr_ptr_gray), .ae_n(ae_n)
    );

    function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic int eff(input logic [OFS_W-1:0] v);
        return (int'(v) >= DEPTH) ? DEPTH - 1 : int'(v);
    endfunction

    function automatic bit exp_ae(input int lvl);
        return lvl > eff(mx);
    endfunction

    function automatic bit exp_af(input int lvl);
        return !(lvl >= DEPTH - eff(my));
    endfunction

    task automatic chk(input logic act, input bit exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic drive_ptrs();
        wr_ptr = cur_w; wr_ptr_gray = to_gray(cur_w);
        rd_ptr = cur_r; rd_ptr_gray = to_gray(cur_r);
    endtask

    task automatic set_level(input int lvl);
        cur_r = PTR_W'($urandom_range(0, 31));
        cur_w = cur_r + PTR_W'(lvl);
        drive_ptrs();
        repeat (4) @(posedge rclk);
        repeat (4) @(posedge wclk);
        #1;
    endtask

    task automatic check_level(input int lvl, input string tag);
        set_level(lvl);
        chk(ae_n, exp_ae(lvl), $sformatf("R1 ae_n %s lvl=%0d X=%0d", tag, lvl, mx));
        chk(af_n, exp_af(lvl), $sformatf("R2 af_n %s lvl=%0d Y=%0d", tag, lvl, my));
    endtask

    task automatic probe(input string tag);
        int lv[4];
        lv[0] = eff(mx); lv[1] = eff(mx) + 1;
        lv[2] = DEPTH - eff(my) - 1; lv[3] = DEPTH - eff(my);
        foreach (lv[i]) if (lv[i] >= 0 && lv[i] <= DEPTH) check_level(lv[i], tag);
    endtask

    task automatic load_par(input logic sel, input logic [OFS_W-1:0] val);
        @(negedge wclk); ld_en = 1'b1; ld_sel = sel; ld_data = val;
        @(negedge wclk); ld_en = 1'b0;
        if (sel) my = val; else mx = val;
    endtask

    task automatic load_ser(input logic [OFS_W-1:0] xv, input logic [OFS_W-1:0] yv);
        logic [2*OFS_W-1:0] v;
        v = {xv, yv};
        for (int i = 2*OFS_W-1; i >= 0; i--) begin
            @(negedge wclk); ser_en = 1'b1; ser_in = v[i];
        end
        @(negedge wclk); ser_en = 1'b0;
        mx = xv; my = yv;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge rclk);
        @(negedge wclk); wrst_n = 1'b1;
        @(negedge rclk); rrst_n = 1'b1;
        repeat (3) @(posedge rclk);
        #1;
        // R5: reset state with pointers at zero
        chk(ae_n, 1'b0, "R5 ae_n after reset");
        chk(af_n, 1'b1, "R5 af_n after reset");
        probe("R5 preset offsets");

        // R3: two read edges after a remote write crossing X+1
        set_level(eff(mx));
        chk(ae_n, 1'b0, "R3 ae_n at X before write");
        @(negedge rclk); cur_w = cur_w + 1'b1; drive_ptrs();
        @(posedge rclk); #1; chk(ae_n, 1'b0, "R3 ae_n after first rclk edge");
        @(posedge rclk); #1; chk(ae_n, 1'b1, "R3 ae_n after second rclk edge");
        @(negedge rclk); cur_r = cur_r + 1'b1; drive_ptrs();
        #1; chk(ae_n, 1'b0, "R3 ae_n local read, no edge");

        // R4: two write edges after a remote read leaving the high-water zone
        set_level(DEPTH - eff(my));
        chk(af_n, 1'b0, "R4 af_n at DEPTH-Y before read");
        @(negedge wclk); cur_r = cur_r + 1'b1; drive_ptrs();
        @(posedge wclk); #1; chk(af_n, 1'b0, "R4 af_n after first wclk edge");
        @(posedge wclk); #1; chk(af_n, 1'b1, "R4 af_n after second wclk edge");
        @(negedge wclk); cur_w = cur_w + 1'b1; drive_ptrs();
        #1; chk(af_n, 1'b0, "R4 af_n local write, no edge");

        // R6: parallel loads
        load_par(1'b0, 5'd6); load_par(1'b1, 5'd4);
        probe("R6 parallel");

        // R7: serial load, then parallel versus serial in one cycle
        load_ser(5'd9, 5'd1);
        probe("R7 serial");
        @(negedge wclk); ld_en = 1'b1; ld_sel = 1'b0; ld_data = 5'd3; ser_en = 1'b1; ser_in = 1'b1;
        @(negedge wclk); ld_en = 1'b0; ser_en = 1'b0;
        mx = 5'd3;
        probe("R7 priority");

        // R8: saturated offsets
        load_par(1'b0, 5'd31); load_par(1'b1, 5'd16);
        probe("R8 saturation");
        check_level(0, "R8 empty");
        check_level(DEPTH, "R8 full");

        // Random mix of programming methods and levels
        for (int it = 0; it < 30; it++) begin
            int how;
            how = $urandom_range(0, 2);
            if (how == 0) begin
                load_par(1'b0, OFS_W'($urandom_range(0, 31)));
                load_par(1'b1, OFS_W'($urandom_range(0, 31)));
                probe("R6 random");
            end else if (how == 1) begin
                load_ser(OFS_W'($urandom_range(0, 31)), OFS_W'($urandom_range(0, 31)));
                probe("R7 random");
            end else begin
                for (int k = 0; k < 12; k++) begin
                    @(negedge wclk); ser_in = $urandom_range(0, 1); ld_data = OFS_W'($urandom_range(0, 31));
                end
                probe("R9 hold");
            end
            check_level($urandom_range(0, DEPTH), "R8 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule